// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs one complete conversion on an external 16-input successive-approximation converter with a built-in analog multiplexer. The host side is a simple strobe interface: it gives a channel number and a one-cycle request. The block then drives the converter's pins through every phase with the spacing that converter needs. It places the channel address, pulses the address latch, gives the input multiplexer time to settle and pulses start. It then waits for the end-of-conversion signal, turns on the converter's tri-state data outputs, takes the result and lets the bus float again. Last, it returns the 8-bit sample, tagged with its channel, together with a one-cycle done strobe.

Every minimum width, setup, hold and settling interval is a parameter counted in system clock cycles. The integrator derives these values from the system clock period. End-of-conversion is asynchronous to the system clock, so it is synchronized before use. Any rising edge of it during a blanking window that follows start is discarded, because the converter can still show the previous conversion's level there. A watchdog counter ends a conversion that never completes and sets a sticky error flag.

Top module: `adc_mux_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, ale_o, start_o, oe_o, done_o and timeout_err_o are all 0.
- R2: A request seen while idle loads ch_i onto mux_addr_o on that clock edge. mux_addr_o then holds that value for the whole time busy_o is high, and ale_o rises only after exactly ADDR_SETUP_CYC cycles of busy with the address in place.
- R3: ale_o is high for exactly ALE_HIGH_CYC cycles. ale_o, start_o and oe_o are never high two at a time.
- R4: After ale_o falls, start_o stays low for exactly ADDR_HOLD_CYC + SETTLE_CYC cycles, so that the address is held and the multiplexer can settle. start_o is then high for exactly START_HIGH_CYC cycles.
- R5: Rising edges of eoc_i, and any high level of it left over from the previous conversion, are ignored during the first EOC_BLANK_CYC cycles after start_o falls. oe_o does not rise before the converter's real end of conversion.
- R6: After a synchronized rising edge of eoc_i that falls outside the blanking window, oe_o is high for exactly DATA_WAIT_CYC cycles. data_i is captured on the last of these cycles and returned on result_o, with the channel of the request on res_ch_o.
- R7: oe_o stays low for exactly FLOAT_CYC cycles before done_o pulses high for one cycle.
- R8: busy_o is high from the cycle after a request is accepted and falls in the cycle in which done_o is high. A request that arrives while busy_o is high is ignored: it starts no conversion, does not change the address and produces no extra done_o.
- R9: If no valid end of conversion is seen within TIMEOUT_CYC cycles of start_o rising, busy_o falls at exactly that point and timeout_err_o is set. No done_o is given for that request.
- R10: timeout_err_o stays set through later conversions until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Conversion request strobe |
| ch_i | input | 4 | Channel to convert |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 8 | Captured conversion result |
| res_ch_o | output | 4 | Channel tag of result_o |
| timeout_err_o | output | 1 | Sticky missing-end-of-conversion flag |
| mux_addr_o | output | 4 | Multiplexer address to converter |
| ale_o | output | 1 | Address latch enable pulse |
| start_o | output | 1 | Conversion start pulse |
| eoc_i | input | 1 | End of conversion, asynchronous |
| oe_o | output | 1 | Converter output enable |
| data_i | input | 8 | Converter data bus |

## Verification
The bench uses short intervals: 2 cycles of address setup, 3 of latch, 2 of hold, 4 of settle, 3 of start, 12 of blanking, 3 of data wait, 3 of float and a 60-cycle timeout. With these values every phase boundary can be measured to the exact cycle against a converter model, and a 30-cycle conversion completes well inside the timeout. The model ends each conversion with end-of-conversion left high and can inject a spurious pulse inside the blanking window, which tests both the stale-level case and the early-edge case. It drives wrong data until output enable has been high for the full wait, so a capture made too early returns a wrong value.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding for the conversion sequencer.
package adc_seq_pkg;

    // Phases of one conversion, in the order they are traversed.
    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_ALE,
        S_HOLD,
        S_SETTLE,
        S_START,
        S_BLANK,
        S_WAIT,
        S_OE,
        S_FLOAT
    } seq_state_t;

endpackage

// File: rtl/adc_sync2.sv
// adc_sync2: two-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level (no pulses shorter than two clocks
// need to be seen). Output is reset low.
module adc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;

    // Two back-to-back flops bring the level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/adc_seq_timer.sv
// adc_seq_timer: loadable down-counter used to time one phase.
// A load of N-1 makes 'expired_o' high after N-1 further clocks, so a
// phase entered on the load edge lasts exactly N cycles. The count
// stops at zero.
module adc_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down toward zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R4: an expired timer stays expired until reloaded (no wrap).
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/adc_mux_seq.sv
// adc_mux_seq: host-side sequencer for a multiplexed SAR converter.
// Accepts a channel and request strobe, then drives address, latch,
// start and output enable with cycle-counted spacing, waits for a
// synchronized end-of-conversion edge outside a blanking window, captures
// the data and returns it with a done strobe. Assumes every *_CYC
// parameter is at least 1 and EOC_BLANK_CYC is shorter than the timeout.
module adc_mux_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W           = 4,
    parameter int DATA_W         = 8,
    parameter int ADDR_SETUP_CYC = 3,
    parameter int ALE_HIGH_CYC   = 10,
    parameter int ADDR_HOLD_CYC  = 3,
    parameter int SETTLE_CYC     = 125,
    parameter int START_HIGH_CYC = 10,
    parameter int EOC_BLANK_CYC  = 750,
    parameter int DATA_WAIT_CYC  = 13,
    parameter int FLOAT_CYC      = 13,
    parameter int TIMEOUT_CYC    = 6500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [CH_W-1:0]   ch_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic              timeout_err_o,
    output logic [CH_W-1:0]   mux_addr_o,
    output logic              ale_o,
    output logic              start_o,
    input  logic              eoc_i,
    output logic              oe_o,
    input  logic [DATA_W-1:0] data_i
);
    // Widest phase length sets the phase-timer width.
    localparam int M1 = (ADDR_SETUP_CYC > ALE_HIGH_CYC) ? ADDR_SETUP_CYC : ALE_HIGH_CYC;
    localparam int M2 = (ADDR_HOLD_CYC > SETTLE_CYC) ? ADDR_HOLD_CYC : SETTLE_CYC;
    localparam int M3 = (START_HIGH_CYC > EOC_BLANK_CYC) ? START_HIGH_CYC : EOC_BLANK_CYC;
    localparam int M4 = (DATA_WAIT_CYC > FLOAT_CYC) ? DATA_WAIT_CYC : FLOAT_CYC;
    localparam int M12 = (M1 > M2) ? M1 : M2;
    localparam int M34 = (M3 > M4) ? M3 : M4;
    localparam int PH_MAX = (M12 > M34) ? M12 : M34;
    localparam int PH_W = $clog2(PH_MAX + 1);
    localparam int WD_W = $clog2(TIMEOUT_CYC + 1);

    seq_state_t state_q, state_d;
    logic [CH_W-1:0] ch_q;
    logic            ph_load, ph_expired;
    logic [PH_W-1:0] ph_val;
    logic            wd_load, wd_expired;
    logic            eoc_s, eoc_prev_q, eoc_rise;

    // Bring the converter's completion flag into the clock domain.
    adc_sync2 u_eoc_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(eoc_i),
        .sync_o (eoc_s)
    );

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eoc_prev_q <= 1'b0;
        else        eoc_prev_q <= eoc_s;
    end
    assign eoc_rise = eoc_s && !eoc_prev_q;

    // Next-state selection: timed phases advance on timer expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_i)      state_d = S_SETUP;
            S_SETUP:  if (ph_expired) state_d = S_ALE;
            S_ALE:    if (ph_expired) state_d = S_HOLD;
            S_HOLD:   if (ph_expired) state_d = S_SETTLE;
            S_SETTLE: if (ph_expired) state_d = S_START;
            S_START:  if (ph_expired) state_d = S_BLANK;
            S_BLANK:  if (ph_expired) state_d = S_WAIT;
            S_WAIT: begin
                if (eoc_rise)        state_d = S_OE;
                else if (wd_expired) state_d = S_IDLE;
            end
            S_OE:     if (ph_expired) state_d = S_FLOAT;
            S_FLOAT:  if (ph_expired) state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    // Phase length loaded on entry to each timed state.
    always_comb begin
        ph_load = (state_d != state_q);
        unique case (state_d)
            S_SETUP:  ph_val = PH_W'(ADDR_SETUP_CYC - 1);
            S_ALE:    ph_val = PH_W'(ALE_HIGH_CYC - 1);
            S_HOLD:   ph_val = PH_W'(ADDR_HOLD_CYC - 1);
            S_SETTLE: ph_val = PH_W'(SETTLE_CYC - 1);
            S_START:  ph_val = PH_W'(START_HIGH_CYC - 1);
            S_BLANK:  ph_val = PH_W'(EOC_BLANK_CYC - 1);
            S_OE:     ph_val = PH_W'(DATA_WAIT_CYC - 1);
            S_FLOAT:  ph_val = PH_W'(FLOAT_CYC - 1);
            default:  ph_val = '0;
        endcase
    end

    adc_seq_timer #(.W(PH_W)) u_phase_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ph_load),
        .load_val_i(ph_val),
        .expired_o (ph_expired)
    );

    // Watchdog armed when start is first driven.
    assign wd_load = (state_d == S_START) && (state_q != S_START);

    adc_seq_timer #(.W(WD_W)) u_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wd_load),
        .load_val_i(WD_W'(TIMEOUT_CYC - 1)),
        .expired_o (wd_expired)
    );

    // State register, channel latch and registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ch_q       <= '0;
            busy_o     <= 1'b0;
            ale_o      <= 1'b0;
            start_o    <= 1'b0;
            oe_o       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_i)
                ch_q <= ch_i;
            busy_o  <= (state_d != S_IDLE);
            ale_o   <= (state_d == S_ALE);
            start_o <= (state_d == S_START);
            oe_o    <= (state_d == S_OE);
        end
    end
    assign mux_addr_o = ch_q;

    // Result capture, done strobe and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o      <= '0;
            res_ch_o      <= '0;
            done_o        <= 1'b0;
            timeout_err_o <= 1'b0;
        end else begin
            if (state_q == S_OE && state_d == S_FLOAT) begin
                result_o <= data_i;
                res_ch_o <= ch_q;
            end
            done_o <= (state_q == S_FLOAT) && (state_d == S_IDLE);
            if (state_q == S_WAIT && state_d == S_IDLE)
                timeout_err_o <= 1'b1;
        end
    end

    // R8
    done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> timeout_err_o);

    // R3
    pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ale_o, start_o, oe_o}) <= 1);

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_addr_o));

    // R6
    oe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(eoc_rise));
endmodule

// File: tb/adc_mux_seq_tb.sv
// Scoreboard bench: a driver task queues expected results, a monitor
// compares them on done and measures every phase length at the pins.
module adc_mux_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_SETUP = 2, P_ALE = 3, P_HOLD = 2, P_SETTLE = 4;
    localparam int P_START = 3, P_BLANK = 12, P_DW = 3, P_FLOAT = 3;
    localparam int P_TMO = 60, CONV_K = 30;

    logic clk = 1'b0, rst_n = 1'b0, req_i = 1'b0, eoc_i = 1'b0;
    logic [3:0] ch_i = '0;
    logic [7:0] data_i = '0;
    logic busy_o, done_o, timeout_err_o, ale_o, start_o, oe_o;
    logic [7:0] result_o;
    logic [3:0] res_ch_o, mux_addr_o;

    int n_chk = 0, n_fail = 0, n_done = 0;
    logic [11:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_mux_seq #(
        .ADDR_SETUP_CYC(P_SETUP), .ALE_HIGH_CYC(P_ALE), .ADDR_HOLD_CYC(P_HOLD),
        .SETTLE_CYC(P_SETTLE), .START_HIGH_CYC(P_START), .EOC_BLANK_CYC(P_BLANK),
        .DATA_WAIT_CYC(P_DW), .FLOAT_CYC(P_FLOAT), .TIMEOUT_CYC(P_TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ch_i(ch_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .res_ch_o(res_ch_o), .timeout_err_o(timeout_err_o),
        .mux_addr_o(mux_addr_o), .ale_o(ale_o), .start_o(start_o),
        .eoc_i(eoc_i), .oe_o(oe_o), .data_i(data_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model: stale EOC, optional glitch, real EOC, gated data.
    logic [7:0] conv_data = '0;
    bit m_glitch = 0, m_never = 0, real_eoc = 0, m_act = 0, m_pstart = 0;
    int m_k = 0, oe_cnt = 0;
    always @(negedge clk) begin
        if (start_o && !m_pstart) begin
            m_k = 0; m_act = 1; real_eoc = 0;
        end else if (m_act) m_k++;
        if (m_act) begin
            if (m_k == 1) eoc_i = 1'b0;
            if (m_glitch && m_k == 4) eoc_i = 1'b1;
            if (m_glitch && m_k == 7) eoc_i = 1'b0;
            if (!m_never && m_k == CONV_K) begin
                eoc_i = 1'b1; real_eoc = 1; m_act = 0;
            end
            if (m_never && m_k > P_TMO + 5) m_act = 0;
        end
        m_pstart = start_o;
        if (oe_o) oe_cnt++; else oe_cnt = 0;
        data_i = (oe_cnt >= P_DW) ? conv_data : ~conv_data;
    end

    // Monitor: phase lengths at the pins and scoreboard compare.
    bit p_busy = 0, p_ale = 0, p_start = 0, p_oe = 0;
    bit ale_done = 0, st_seen = 0, st_done = 0, oe_done = 0, addr_bad = 0;
    int setup_n = 0, ale_n = 0, gap_n = 0, st_n = 0, oe_n = 0, flt_n = 0, tmo_n = 0;
    logic [3:0] addr_ref = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !p_busy) begin
                ale_done = 0; st_seen = 0; st_done = 0; oe_done = 0; addr_bad = 0;
                setup_n = 0; ale_n = 0; gap_n = 0; st_n = 0; oe_n = 0; flt_n = 0; tmo_n = 0;
                addr_ref = mux_addr_o;
            end
            if (busy_o && mux_addr_o != addr_ref) addr_bad = 1;
            if (busy_o && !ale_o && !p_ale && !ale_done) setup_n++;
            if (ale_o) begin
                if (!p_ale) check(setup_n == P_SETUP, "R2 setup cycles", setup_n, P_SETUP);
                ale_n++;
            end else if (p_ale) begin
                check(ale_n == P_ALE, "R3 ale width", ale_n, P_ALE);
                ale_done = 1;
            end
            if (ale_done && !start_o && !st_seen) gap_n++;
            if (start_o) begin
                if (!p_start) begin
                    check(gap_n == P_HOLD + P_SETTLE, "R4 hold+settle gap", gap_n, P_HOLD + P_SETTLE);
                    st_seen = 1;
                end
                st_n++;
            end else if (p_start) check(st_n == P_START, "R4 start width", st_n, P_START);
            if (st_seen && busy_o) tmo_n++;
            if (oe_o) begin
                if (!p_oe) check(real_eoc, "R5 oe before real eoc", 0, 1);
                oe_n++;
            end else if (p_oe) begin
                check(oe_n == P_DW, "R6 oe width", oe_n, P_DW);
                oe_done = 1;
            end
            if (oe_done && busy_o && !oe_o) flt_n++;
            if (p_busy && !busy_o) begin
                check(!addr_bad, "R2 address held while busy", addr_bad, 0);
                if (done_o) begin
                    check(flt_n == P_FLOAT, "R7 float gap", flt_n, P_FLOAT);
                end else begin
                    check(tmo_n == P_TMO, "R9 timeout point", tmo_n, P_TMO);
                    check(timeout_err_o, "R9 error flag", timeout_err_o, 1);
                end
            end
            if (done_o) begin
                n_done++;
                check(!busy_o && p_busy, "R8 busy falls with done", busy_o, 0);
                if (exp_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
                else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(result_o == e[7:0], "R6 result", result_o, e[7:0]);
                    check(res_ch_o == e[11:8], "R6 channel tag", res_ch_o, e[11:8]);
                end
            end
        end
        p_busy = busy_o; p_ale = ale_o; p_start = start_o; p_oe = oe_o;
    end

    // Driver: one conversion, optionally with an extra request while busy.
    task automatic convert(input logic [3:0] ch, input logic [7:0] d,
                           input bit glitch, input bit never, input bit extra_req);
        @(negedge clk);
        conv_data = d; m_glitch = glitch; m_never = never;
        if (!never) exp_q.push_back({ch, d});
        ch_i = ch; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(busy_o && mux_addr_o == ch, "R2 accept", mux_addr_o, ch);
        if (extra_req) begin
            while (!start_o) @(negedge clk);
            ch_i = ~ch; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state while reset held
        check({busy_o, ale_o, start_o, oe_o, done_o, timeout_err_o} == 6'b0,
              "R1 reset outputs", {busy_o, ale_o, start_o, oe_o, done_o, timeout_err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy_o, ale_o, start_o, oe_o, done_o, timeout_err_o} == 6'b0,
              "R1 idle after reset", {busy_o, ale_o, start_o, oe_o, done_o, timeout_err_o}, 0);
        convert(4'd3, 8'h5A, 1'b1, 1'b0, 1'b0);   // R5 glitch in blank window
        convert(4'd15, 8'hC3, 1'b0, 1'b0, 1'b1);  // R8 request while busy
        repeat (6) @(negedge clk);
        check(!busy_o, "R8 ignored request left idle", busy_o, 0);
        check(n_done == 2, "R8 done count", n_done, 2);
        convert(4'd0, 8'h00, 1'b1, 1'b0, 1'b0);
        check(!timeout_err_o, "R9 no error on good runs", timeout_err_o, 0);
        convert(4'd9, 8'hFF, 1'b0, 1'b1, 1'b0);   // R9 missing end of conversion
        check(n_done == 3, "R9 no done on timeout", n_done, 3);
        convert(4'd6, 8'h81, 1'b0, 1'b0, 1'b0);
        check(timeout_err_o, "R10 error stays set", timeout_err_o, 1);
        check(exp_q.size() == 0, "R6 all results returned", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule